// File: doc/BRIEF.md
# Tagged Conversion Result Queue with Interrupt Aggregation

This block collects converter results as they are produced and holds them, oldest first, in a sixteen-entry queue. Each entry keeps a 20-bit sample value together with the 3-bit number of the slot that produced it. Software reaches the queue through a small register port.

The port offers two views of the queue head. The inspect view only returns the head. The consume view returns the head and also removes it, but only when a destructive-read enable bit is set. A write of any value to the inspect view removes one entry.

The block also folds the queue's fill level and a set of external event pulses into one interrupt line. This uses sticky status bits, an enable mask, write-one-to-clear and a software force register.

The read word is combinational on the current address and read strobe. A removal caused by a read takes effect at the clock edge that ends the read cycle. All other state also updates on that edge.

Top module: `conv_result_fifo`

## Requirements
- R1: The queue holds 16 entries and returns them in arrival order. A read of address 0 or 1 returns a word with bit 31 zero, the head slot number in bits 30:28, the number of valid entries in bits 27:20 and the head sample value in bits 19:0.
- R2: A read of address 0 (inspect view) never changes the queue. While the queue is empty, bits 30:28 and 19:0 of the read word are zero.
- R3: A read of address 1 (consume view) removes the head entry only when bit 0 of the configuration register at address 2 is 1. Otherwise it behaves exactly as a read of address 0.
- R4: A write of any value to address 0 removes one entry when the count is above zero. When the queue is empty, the write has no effect.
- R5: A result pushed while the count is 16 and no removal happens in the same cycle is dropped. The count and the stored entries are left unchanged.
- R6: A push and a removal in the same cycle keep the count unchanged. The head advances and the new result is appended, including when the queue is full.
- R7: Status bit 2 is set when the count moves from below 12 to 12 or more. Status bit 3 is set when the count moves from below 16 to 16. Neither bit is set again while the count merely stays at or above its threshold.
- R8: Status bits are sticky. Event inputs set these status bits: conversion done sets bit 0, scan done sets bit 1, window excursion sets bit 4, window incursion sets bit 5, transfer done sets bit 6 and transfer error sets bit 7.
- R9: Writing to address 5 clears every status bit whose write-data bit is 1. An event or force arriving in the same cycle wins over the clear.
- R10: Writing to address 6 sets every status bit whose write-data bit is 1.
- R11: The enable mask is written and read at address 3, and the status is read at address 4. The irq output is 1 exactly when some status bit and its enable bit are both 1. Reads of addresses 5, 6 and 7 return zero.
- R12: After reset, the count, status, enable mask and configuration are all zero, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_valid | input | 1 | Push strobe for a new result |
| res_slot | input | 3 | Slot number of the new result |
| res_data | input | 20 | Sample value of the new result |
| evt_conv_done | input | 1 | Conversion done event pulse |
| evt_scan_done | input | 1 | Scan done event pulse |
| evt_win_exc | input | 1 | Window excursion event pulse |
| evt_win_inc | input | 1 | Window incursion event pulse |
| evt_xfer_done | input | 1 | Transfer done event pulse |
| evt_xfer_err | input | 1 | Transfer error event pulse |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Aggregated interrupt |

## Verification
The queue is first filled one result at a time from empty to beyond full, with the inspect word checked after every push. This separates a correct count and head from a queue that loses, reorders or overwrites entries. It also shows whether the fill flags fire only on the crossing, not while the level is held.

The queue is then drained through each removal path: consume reads with the enable off and then on, inspect writes, and a push coinciding with a removal at full. Each path is told apart by whether the count actually moves.

Every interrupt bit is forced, masked, unmasked and cleared one at a time, and every event input is pulsed alone. This exposes any swapped bit position or a clear that overrides a same-cycle event.

// File: rtl/crf_pkg.sv
package crf_pkg;

  localparam int SLOT_W = 3;
  localparam int DATA_W = 20;
  localparam int CNTF_W = 8;
  localparam int IRQ_N  = 8;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] data;
  } crf_entry_t;

  typedef enum logic [2:0] {
    RA_INSPECT = 3'd0,
    RA_CONSUME = 3'd1,
    RA_CONFIG  = 3'd2,
    RA_ENABLE  = 3'd3,
    RA_STATUS  = 3'd4,
    RA_CLEAR   = 3'd5,
    RA_FORCE   = 3'd6
  } crf_addr_e;

  localparam int IB_CONV    = 0;
  localparam int IB_SCAN    = 1;
  localparam int IB_FILL75  = 2;
  localparam int IB_FILL100 = 3;
  localparam int IB_WEXC    = 4;
  localparam int IB_WINC    = 5;
  localparam int IB_XDONE   = 6;
  localparam int IB_XERR    = 7;

endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/crf_store.sv
module crf_store
  import crf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  crf_entry_t       push_ent,
  input  logic             pop_req,
  output crf_entry_t       head_ent,
  output logic [CNT_W-1:0] count_q,
  output logic             fill75_evt,
  output logic             fill100_evt
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int THR75  = (DEPTH * 3) / 4;
  localparam int THR100 = DEPTH;

  crf_entry_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_d;
  logic             do_pop, do_push;

  // next-state
  always_comb begin
    do_pop  = pop_req && (count_q != '0);
    do_push = push_req && ((count_q != CNT_W'(DEPTH)) || do_pop);

    wr_ptr_d = wr_ptr_q;
    if (do_push) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end

    rd_ptr_d = rd_ptr_q;
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end

    unique case ({do_push, do_pop})
      2'b10:   count_d = count_q + CNT_W'(1);
      2'b01:   count_d = count_q - CNT_W'(1);
      default: count_d = count_q;
    endcase

    fill75_evt  = (count_q < CNT_W'(THR75))  && (count_d >= CNT_W'(THR75));
    fill100_evt = (count_q < CNT_W'(THR100)) && (count_d >= CNT_W'(THR100));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage: one clock enable per entry, no reset on data
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic ent_we;
    assign ent_we = do_push && (wr_ptr_q == PTR_W'(gi));
    always_ff @(posedge clk) begin
      if (ent_we) begin
        mem_q[gi] <= push_ent;
      end
    end
  end

  assign head_ent = (count_q == '0) ? '0 : mem_q[rd_ptr_q];

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && count_q == '0) |=> (count_q == '0));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && count_q == CNT_W'(DEPTH)) |=>
      (count_q == CNT_W'(DEPTH) && $stable(wr_ptr_q)));

  // R6
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && count_q != '0) |=> $stable(count_q));

endmodule

// File: rtl/crf_irq.sv
module crf_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_evt,
  input  logic         en_we,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] enable_q,
  output logic [N-1:0] status_q,
  output logic         irq
);

  logic [N-1:0] status_d;
  logic [N-1:0] enable_d;

  // next-state, one generated cell per status bit
  for (genvar gk = 0; gk < N; gk++) begin : g_bit
    logic set_k, clr_k;
    assign set_k = src_evt[gk] | (set_we & wbits[gk]);
    assign clr_k = clr_we & wbits[gk];
    assign status_d[gk] = set_k | (status_q[gk] & ~clr_k);
  end

  assign enable_d = en_we ? wbits : enable_q;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
    end
  end

  assign irq = |(status_q & enable_q);

  // R8
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((status_q & $past(src_evt)) == $past(src_evt)));

  // R10
  force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((status_q & $past(wbits)) == $past(wbits)));

  // R9
  clear_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we && src_evt == '0) |=> ((status_q & $past(wbits)) == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && !set_we && src_evt == '0) |=> $stable(status_q));

endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
  import crf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        res_valid,
  input  logic [2:0]  res_slot,
  input  logic [19:0] res_data,
  input  logic        evt_conv_done,
  input  logic        evt_scan_done,
  input  logic        evt_win_exc,
  input  logic        evt_win_inc,
  input  logic        evt_xfer_done,
  input  logic        evt_xfer_err,
  input  logic [2:0]  reg_addr,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int THR75 = (DEPTH * 3) / 4;

  logic             rst_sync_n;
  crf_entry_t       push_ent, head_ent;
  logic [CNT_W-1:0] cnt_q;
  logic             fill75_evt, fill100_evt;
  logic             pop_req;
  logic             cfg_dest_q, cfg_dest_d;
  logic [IRQ_N-1:0] src_evt, enable_q, status_q;
  logic             en_we, set_we, clr_we;
  logic [31:0]      head_word;
  logic [23:0]      wdata_unused;

  assign wdata_unused = reg_wdata[31:8];

  crf_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // register decode
  always_comb begin
    pop_req = (reg_rd && reg_addr == RA_CONSUME && cfg_dest_q)
           || (reg_wr && reg_addr == RA_INSPECT);
    en_we   = reg_wr && reg_addr == RA_ENABLE;
    set_we  = reg_wr && reg_addr == RA_FORCE;
    clr_we  = reg_wr && reg_addr == RA_CLEAR;
    cfg_dest_d = (reg_wr && reg_addr == RA_CONFIG) ? reg_wdata[0] : cfg_dest_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_dest_q <= 1'b0;
    end else begin
      cfg_dest_q <= cfg_dest_d;
    end
  end

  assign push_ent.slot = res_slot;
  assign push_ent.data = res_data;

  crf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .push_req    (res_valid),
    .push_ent    (push_ent),
    .pop_req     (pop_req),
    .head_ent    (head_ent),
    .count_q     (cnt_q),
    .fill75_evt  (fill75_evt),
    .fill100_evt (fill100_evt)
  );

  always_comb begin
    src_evt             = '0;
    src_evt[IB_CONV]    = evt_conv_done;
    src_evt[IB_SCAN]    = evt_scan_done;
    src_evt[IB_FILL75]  = fill75_evt;
    src_evt[IB_FILL100] = fill100_evt;
    src_evt[IB_WEXC]    = evt_win_exc;
    src_evt[IB_WINC]    = evt_win_inc;
    src_evt[IB_XDONE]   = evt_xfer_done;
    src_evt[IB_XERR]    = evt_xfer_err;
  end

  crf_irq #(.N(IRQ_N)) i_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .src_evt  (src_evt),
    .en_we    (en_we),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .wbits    (reg_wdata[IRQ_N-1:0]),
    .enable_q (enable_q),
    .status_q (status_q),
    .irq      (irq)
  );

  // read mux
  assign head_word = {1'b0, head_ent.slot, CNTF_W'(cnt_q), head_ent.data};

  always_comb begin
    unique case (reg_addr)
      RA_INSPECT, RA_CONSUME: reg_rdata = head_word;
      RA_CONFIG:              reg_rdata = {31'd0, cfg_dest_q};
      RA_ENABLE:              reg_rdata = {{(32-IRQ_N){1'b0}}, enable_q};
      RA_STATUS:              reg_rdata = {{(32-IRQ_N){1'b0}}, status_q};
      default:                reg_rdata = 32'd0;
    endcase
  end

  // R7
  fill_edge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_q >= CNT_W'(THR75) && $past(cnt_q) < CNT_W'(THR75)) |-> status_q[IB_FILL75]);

  // R7
  full_edge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_q == CNT_W'(DEPTH) && $past(cnt_q) != CNT_W'(DEPTH)) |-> status_q[IB_FILL100]);

  // R3
  keep_view_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rd && !reg_wr && !res_valid && !cfg_dest_q) |=> $stable(cnt_q));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable_q == '0) |-> !irq);

endmodule

// File: tb/test_conv_result_fifo.sv
module test_conv_result_fifo;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid;
  logic [2:0]  res_slot;
  logic [19:0] res_data;
  logic        evt_conv_done, evt_scan_done, evt_win_exc, evt_win_inc;
  logic        evt_xfer_done, evt_xfer_err;
  logic [2:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [22:0] model_q [$];

  always #5 clk = ~clk;

  conv_result_fifo i_conv_result_fifo (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
    .res_data(res_data), .evt_conv_done(evt_conv_done), .evt_scan_done(evt_scan_done),
    .evt_win_exc(evt_win_exc), .evt_win_inc(evt_win_inc), .evt_xfer_done(evt_xfer_done),
    .evt_xfer_err(evt_xfer_err), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    if (model_q.size() == 0) return 32'd0;
    return {1'b0, model_q[0][22:20], 8'(model_q.size()), model_q[0][19:0]};
  endfunction

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    cyc();
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic push(input logic [2:0] s, input logic [19:0] d);
    res_valid = 1'b1; res_slot = s; res_data = d;
    cyc();
    res_valid = 1'b0;
    if (model_q.size() < 16) model_q.push_back({s, d});
  endtask

  function automatic logic [19:0] pat(input int n);
    return 20'((n * 40503 + 7) ^ (n << 13));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b1; res_valid = 0; res_slot = 0; res_data = 0;
    evt_conv_done = 0; evt_scan_done = 0; evt_win_exc = 0; evt_win_inc = 0;
    evt_xfer_done = 0; evt_xfer_err = 0;
    reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    #2 rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R12 reset state
    rd_reg(3'd0, v); chk("R12 count", v, 32'd0);
    rd_reg(3'd4, v); chk("R12 status", v, 32'd0);
    rd_reg(3'd3, v); chk("R12 enable", v, 32'd0);
    rd_reg(3'd2, v); chk("R12 config", v, 32'd0);
    chk("R12 irq", {31'd0, irq}, 32'd0);

    // R4 write-pop on empty has no effect
    wr_reg(3'd0, 32'hFFFF_FFFF);
    rd_reg(3'd0, v); chk("R4 empty write-pop", v, 32'd0);

    // R1 R2 R7 fill sweep
    for (int n = 1; n <= 16; n++) begin
      push(3'(n), pat(n));
      rd_reg(3'd0, v); chk("R1 word after push", v, exp_word());
      rd_reg(3'd0, v); chk("R2 inspect keeps queue", v, exp_word());
      rd_reg(3'd4, v);
      if (n == 11) chk("R7 no fill75 below 12", {31'd0, v[2]}, 32'd0);
      if (n == 12) begin
        chk("R7 fill75 at 12", {31'd0, v[2]}, 32'd1);
        wr_reg(3'd5, 32'h4);
      end
      if (n == 13) chk("R7 fill75 not re-set at 13", {31'd0, v[2]}, 32'd0);
      if (n == 15) chk("R7 no fill100 at 15", {31'd0, v[3]}, 32'd0);
      if (n == 16) chk("R7 fill100 at 16", {31'd0, v[3]}, 32'd1);
    end

    // R5 drop on full
    wr_reg(3'd5, 32'hFF);
    push(3'd7, 20'hABCDE);
    rd_reg(3'd0, v); chk("R5 push to full dropped", v, exp_word());
    rd_reg(3'd4, v); chk("R7 fill100 held level no re-set", {31'd0, v[3]}, 32'd0);

    // R6 simultaneous push and pop at full
    res_valid = 1'b1; res_slot = 3'd5; res_data = 20'h5A5A5;
    reg_addr = 3'd0; reg_wdata = 32'd0; reg_wr = 1'b1;
    cyc();
    res_valid = 1'b0; reg_wr = 1'b0;
    void'(model_q.pop_front());
    model_q.push_back({3'd5, 20'h5A5A5});
    rd_reg(3'd0, v); chk("R6 push+pop at full", v, exp_word());
    rd_reg(3'd4, v); chk("R6 fill100 not re-set", {31'd0, v[3]}, 32'd0);

    // R3 consume view without enable
    rd_reg(3'd1, v); chk("R3 consume view disabled word", v, exp_word());
    rd_reg(3'd1, v); chk("R3 consume view disabled no pop", v, exp_word());

    // R3 with enable, drain in order
    wr_reg(3'd2, 32'd1);
    rd_reg(3'd2, v); chk("R3 config readback", v, 32'd1);
    for (int k = 0; k < 16; k++) begin
      rd_reg(3'd1, v); chk("R1 R3 consume order", v, exp_word());
      void'(model_q.pop_front());
    end
    rd_reg(3'd0, v); chk("R2 empty reads zero", v, 32'd0);
    rd_reg(3'd1, v); chk("R3 consume on empty", v, 32'd0);
    wr_reg(3'd2, 32'd0);

    // R6 push+pop at mid level, then R4 write-pop drain
    for (int n = 0; n < 5; n++) push(3'(n + 2), pat(n + 100));
    res_valid = 1'b1; res_slot = 3'd1; res_data = 20'h12345;
    reg_addr = 3'd0; reg_wr = 1'b1;
    cyc();
    res_valid = 1'b0; reg_wr = 1'b0;
    void'(model_q.pop_front());
    model_q.push_back({3'd1, 20'h12345});
    rd_reg(3'd0, v); chk("R6 push+pop mid level", v, exp_word());
    while (model_q.size() > 0) begin
      wr_reg(3'd0, 32'd0);
      void'(model_q.pop_front());
      rd_reg(3'd0, v); chk("R4 write-pop drain", v, exp_word());
    end

    // R10 R11 R9 per-bit force/mask/clear
    wr_reg(3'd5, 32'hFF);
    for (int k = 0; k < 8; k++) begin
      wr_reg(3'd3, 32'(1 << k));
      rd_reg(3'd3, v); chk("R11 enable readback", v, 32'(1 << k));
      chk("R11 irq idle", {31'd0, irq}, 32'd0);
      wr_reg(3'd6, 32'(1 << k));
      rd_reg(3'd4, v); chk("R10 force bit", v, 32'(1 << k));
      chk("R11 irq enabled", {31'd0, irq}, 32'd1);
      wr_reg(3'd3, 32'(~(1 << k) & 8'hFF));
      chk("R11 irq masked", {31'd0, irq}, 32'd0);
      wr_reg(3'd5, 32'(1 << k));
      rd_reg(3'd4, v); chk("R9 clear bit", v, 32'd0);
    end
    wr_reg(3'd3, 32'd0);

    // R8 event inputs and stickiness
    for (int k = 0; k < 6; k++) begin
      logic [7:0] expb;
      evt_conv_done = (k == 0); evt_scan_done = (k == 1); evt_win_exc = (k == 2);
      evt_win_inc = (k == 3); evt_xfer_done = (k == 4); evt_xfer_err = (k == 5);
      cyc();
      {evt_conv_done, evt_scan_done, evt_win_exc, evt_win_inc, evt_xfer_done, evt_xfer_err} = '0;
      case (k)
        0: expb = 8'h01; 1: expb = 8'h02; 2: expb = 8'h10;
        3: expb = 8'h20; 4: expb = 8'h40; default: expb = 8'h80;
      endcase
      cyc();
      rd_reg(3'd4, v); chk("R8 event bit sticky", v, {24'd0, expb});
      wr_reg(3'd5, 32'hFF);
    end

    // R9 event wins over same-cycle clear
    wr_reg(3'd6, 32'h1);
    reg_addr = 3'd5; reg_wdata = 32'h1; reg_wr = 1'b1; evt_conv_done = 1'b1;
    cyc();
    reg_wr = 1'b0; evt_conv_done = 1'b0;
    rd_reg(3'd4, v); chk("R9 event beats clear", v, 32'h1);

    // R11 write-only addresses read zero
    rd_reg(3'd5, v); chk("R11 addr5 reads zero", v, 32'd0);
    rd_reg(3'd6, v); chk("R11 addr6 reads zero", v, 32'd0);
    rd_reg(3'd7, v); chk("R11 addr7 reads zero", v, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule